// File: doc/BRIEF.md
# Writeback-Absorbing Cache Access Controller

This block is the request front end of a lower-level, set-associative cache. The upper level presents one request at a time: a read, a write, a store-conditional or a writeback. The block looks up the set and checks the frame's permission. It then either satisfies the request locally or reports it as a miss to be forwarded to the miss-handling logic. All addresses are block addresses, and every data transfer covers a whole block.

A writeback is absorbed locally when possible. When no copy is present, a victim frame is chosen by a per-set round-robin pointer. A dirty victim leaves through a write-buffer push port, stamped with the current cycle plus the hit latency. A victim whose block has an outstanding upgrade, signalled on the pin port, cannot be replaced, and the writeback is then forwarded instead. A store-conditional that finds no copy at all fails at once. A grant port lets the miss-handling logic install or upgrade a block. It has priority over requests in the same cycle.

Top module: `cache_ctl`

## Requirements
- R1: Command codes on `req_cmd` are 0 read, 1 write, 2 store-conditional and 3 writeback. `req_ready` equals the inverse of `fill_valid`. Exactly one cycle after a request is accepted, `out_valid` pulses with `out_code` set to 0 for hit, 1 for miss-forward or 2 for store-conditional fail. After reset all outputs and counters are zero.
- R2: A read hits on any valid matching frame. A write or store-conditional hits only on a writable frame. On such a hit `resp_valid` pulses with `resp_data` holding the block data for a read, 0 for a write and 1 for a store-conditional. A write or store-conditional hit replaces the block data.
- R3: A write or store-conditional that finds a valid but read-only frame gets code 1 with no response and no state change. A store-conditional in this case does not take the fail path.
- R4: A store-conditional with no matching frame gets code 2, and `resp_valid` pulses with `resp_data` = 0.
- R5: A writeback that hits overwrites the block and marks it dirty. It leaves the permission unchanged, so a later write to a read-only frame still misses.
- R6: A writeback miss installs the block in the set's round-robin victim way. The installed frame is valid, read-only and dirty, and the pointer advances.
- R7: When the victim frame is valid and its block address equals `pin_addr` while `pin_valid` is high, the writeback gets code 1 and the cache is unchanged.
- R8: Replacing a dirty victim pulses `wb_push` one cycle after acceptance. The push carries the victim's block address, its data and `wb_time` = `now_cycle` + HIT_LAT.
- R9: A writeback never raises `resp_valid`. An absorbed writeback gets code 0.
- R10: A writeback whose `req_size` differs from the block size in bytes gets code 1 and allocates nothing.
- R11: Field k (bits k*CNT_W upward) of `hit_count` and of `miss_count` counts the code-0 outcomes and the code-1 or code-2 outcomes for command k. Each field saturates at all ones.
- R12: A grant with `fill_excl` set installs a clean, writable block through the victim way. On a frame that is already present it only adds write permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_cmd | input | 2 | Command code |
| req_addr | input | BA_W | Block address |
| req_size | input | 8 | Payload size in bytes |
| req_data | input | BLK_W | Block payload |
| now_cycle | input | TIME_W | Current cycle number |
| pin_valid | input | 1 | An upgrade is outstanding |
| pin_addr | input | BA_W | Block address of that upgrade |
| fill_valid | input | 1 | Grant from miss handling |
| fill_excl | input | 1 | Grant carries write permission |
| fill_addr | input | BA_W | Grant block address |
| fill_data | input | BLK_W | Grant block data |
| out_valid | output | 1 | Outcome strobe |
| out_code | output | 2 | Outcome code |
| resp_valid | output | 1 | Response to requester |
| resp_data | output | BLK_W | Response data |
| wb_push | output | 1 | Write-buffer push |
| wb_addr | output | BA_W | Victim block address |
| wb_data | output | BLK_W | Victim data |
| wb_time | output | TIME_W | Issue time for the push |
| hit_count | output | 4*CNT_W | Per-command hit counters |
| miss_count | output | 4*CNT_W | Per-command miss counters |

## Verification
A grant and a request can arrive in the same cycle, and both want the single lookup port and the frame arrays. The bench raises both together. It checks that the request is held, with no outcome in that cycle. It then checks that the request completes one cycle after the grant is removed, and that the granted block is usable. A second case combines writeback absorption with a dirty eviction in one step. The bench judges it on the outcome code and the push contents together.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_SCOND = 2'd2,
        CMD_WBACK = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        OUT_HIT    = 2'd0,
        OUT_FWD    = 2'd1,
        OUT_SCFAIL = 2'd2
    } outcome_e;

    typedef struct packed {
        logic valid;
        logic writable;
        logic dirty;
    } line_state_t;

    function automatic logic needs_excl(cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_SCOND);
    endfunction

endpackage

// File: rtl/cc_tag_match.sv
module cc_tag_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 11,
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = way_valid[w] && (way_tag[w] == look_tag);
        end
    endgenerate

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cc_victim_rr.sv
module cc_victim_rr #(
    parameter int SETS  = 4,
    parameter int WAYS  = 2,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             advance,
    output logic [WAY_W-1:0] vic_way
);
    logic [WAY_W-1:0] ptr [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) ptr[s] <= '0;
        end else if (advance) begin
            if (ptr[set_idx] == WAY_W'(WAYS - 1)) ptr[set_idx] <= '0;
            else                                  ptr[set_idx] <= ptr[set_idx] + 1'b1;
        end
    end

    assign vic_way = ptr[set_idx];
endmodule

// File: rtl/cc_sat_counters.sv
module cc_sat_counters #(
    parameter int NCMD  = 4,
    parameter int CNT_W = 32,
    parameter int CMD_W = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bump_hit,
    input  logic                  bump_miss,
    input  logic [CMD_W-1:0]      cmd,
    output logic [NCMD*CNT_W-1:0] hit_vec,
    output logic [NCMD*CNT_W-1:0] miss_vec
);
    generate
        for (genvar k = 0; k < NCMD; k++) begin : g_cmd
            logic [CNT_W-1:0] h_q, m_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    h_q <= '0;
                    m_q <= '0;
                end else begin
                    if (bump_hit && cmd == CMD_W'(k) && h_q != '1)  h_q <= h_q + 1'b1;
                    if (bump_miss && cmd == CMD_W'(k) && m_q != '1) m_q <= m_q + 1'b1;
                end
            end
            assign hit_vec[k*CNT_W +: CNT_W]  = h_q;
            assign miss_vec[k*CNT_W +: CNT_W] = m_q;
        end
    endgenerate
endmodule

// File: rtl/cache_ctl.sv
module cache_ctl
    import cachectl_pkg::*;
#(
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int BLK_BYTES = 8,
    parameter int BA_W      = 13,
    parameter int TIME_W    = 32,
    parameter int HIT_LAT   = 3,
    parameter int CNT_W     = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_cmd,
    input  logic [BA_W-1:0]     req_addr,
    input  logic [7:0]          req_size,
    input  logic [BLK_BYTES*8-1:0] req_data,
    input  logic [TIME_W-1:0]   now_cycle,
    input  logic                pin_valid,
    input  logic [BA_W-1:0]     pin_addr,
    input  logic                fill_valid,
    input  logic                fill_excl,
    input  logic [BA_W-1:0]     fill_addr,
    input  logic [BLK_BYTES*8-1:0] fill_data,
    output logic                out_valid,
    output logic [1:0]          out_code,
    output logic                resp_valid,
    output logic [BLK_BYTES*8-1:0] resp_data,
    output logic                wb_push,
    output logic [BA_W-1:0]     wb_addr,
    output logic [BLK_BYTES*8-1:0] wb_data,
    output logic [TIME_W-1:0]   wb_time,
    output logic [4*CNT_W-1:0]  hit_count,
    output logic [4*CNT_W-1:0]  miss_count
);
    localparam int BLK_W = BLK_BYTES * 8;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = BA_W - IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    // frame arrays
    logic [SETS-1:0][WAYS-1:0]            st_valid, st_writ, st_dirty;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
    logic [SETS-1:0][WAYS-1:0][BLK_W-1:0] data_q;

    // shared lookup port: grant wins over request
    logic            do_fill, do_req;
    logic [BA_W-1:0] sel_addr;
    logic [IDX_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    cmd_e            cmd;

    assign do_fill   = fill_valid;
    assign req_ready = !fill_valid;
    assign do_req    = req_valid && req_ready;
    assign sel_addr  = do_fill ? fill_addr : req_addr;
    assign set_i     = sel_addr[IDX_W-1:0];
    assign tag_i     = sel_addr[BA_W-1:IDX_W];
    assign cmd       = cmd_e'(req_cmd);

    logic             hit;
    logic [WAY_W-1:0] hit_way, vic_way;

    cc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .way_valid (st_valid[set_i]),
        .way_tag   (tag_q[set_i]),
        .look_tag  (tag_i),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    logic adv_rr;

    cc_victim_rr #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_vic (
        .clk     (clk),
        .rst     (rst),
        .set_idx (set_i),
        .advance (adv_rr),
        .vic_way (vic_way)
    );

    // victim view
    logic             vic_valid, vic_dirty, vic_pinned, repl_ok;
    logic [TAG_W-1:0] vic_tag;
    logic             hit_writ, hit_dirty;

    assign vic_valid  = st_valid[set_i][vic_way];
    assign vic_dirty  = st_dirty[set_i][vic_way];
    assign vic_tag    = tag_q[set_i][vic_way];
    assign vic_pinned = pin_valid && vic_valid && (pin_addr == {vic_tag, set_i});
    assign repl_ok    = !vic_pinned;
    assign hit_writ   = st_writ[set_i][hit_way];
    assign hit_dirty  = st_dirty[set_i][hit_way];

    // action decode
    logic             upd_en, upd_tag_en, upd_data_en;
    logic [WAY_W-1:0] upd_way;
    line_state_t      upd_st;
    logic [BLK_W-1:0] upd_data;
    logic             push_en;
    logic             out_en, rsp_en;
    outcome_e         code;
    logic [BLK_W-1:0] rsp_dat;
    logic             cnt_hit, cnt_miss;
    logic             size_ok, perm_ok;

    assign size_ok = (req_size == 8'(BLK_BYTES));
    assign perm_ok = hit && (needs_excl(cmd) ? hit_writ : 1'b1);

    always_comb begin
        upd_en      = 1'b0;
        upd_tag_en  = 1'b0;
        upd_data_en = 1'b0;
        upd_way     = hit_way;
        upd_st      = '{valid: 1'b1, writable: hit_writ, dirty: hit_dirty};
        upd_data    = req_data;
        adv_rr      = 1'b0;
        push_en     = 1'b0;
        out_en      = 1'b0;
        rsp_en      = 1'b0;
        rsp_dat     = '0;
        code        = OUT_FWD;
        cnt_hit     = 1'b0;
        cnt_miss    = 1'b0;

        if (do_fill) begin
            if (hit) begin
                upd_en          = 1'b1;
                upd_st.writable = hit_writ | fill_excl;
            end else if (repl_ok) begin
                upd_en      = 1'b1;
                upd_way     = vic_way;
                upd_st      = '{valid: 1'b1, writable: fill_excl, dirty: 1'b0};
                upd_tag_en  = 1'b1;
                upd_data_en = 1'b1;
                upd_data    = fill_data;
                adv_rr      = 1'b1;
                push_en     = vic_valid && vic_dirty;
            end
        end else if (do_req) begin
            out_en = 1'b1;
            if (cmd == CMD_WBACK && !size_ok) begin
                cnt_miss = 1'b1;
            end else if (perm_ok) begin
                code    = OUT_HIT;
                cnt_hit = 1'b1;
                unique case (cmd)
                    CMD_READ: begin
                        rsp_en  = 1'b1;
                        rsp_dat = data_q[set_i][hit_way];
                    end
                    CMD_WRITE, CMD_SCOND: begin
                        upd_en       = 1'b1;
                        upd_data_en  = 1'b1;
                        upd_st.dirty = 1'b1;
                        rsp_en       = 1'b1;
                        rsp_dat      = (cmd == CMD_SCOND) ? BLK_W'(1) : '0;
                    end
                    default: begin
                        upd_en       = 1'b1;
                        upd_data_en  = 1'b1;
                        upd_st.dirty = 1'b1;
                    end
                endcase
            end else if (cmd == CMD_WBACK) begin
                if (repl_ok) begin
                    code        = OUT_HIT;
                    cnt_hit     = 1'b1;
                    upd_en      = 1'b1;
                    upd_way     = vic_way;
                    upd_st      = '{valid: 1'b1, writable: 1'b0, dirty: 1'b1};
                    upd_tag_en  = 1'b1;
                    upd_data_en = 1'b1;
                    adv_rr      = 1'b1;
                    push_en     = vic_valid && vic_dirty;
                end else begin
                    cnt_miss = 1'b1;
                end
            end else begin
                cnt_miss = 1'b1;
                if (!hit && cmd == CMD_SCOND) begin
                    code   = OUT_SCFAIL;
                    rsp_en = 1'b1;
                end
            end
        end
    end

    // state update
    always_ff @(posedge clk) begin
        if (rst) begin
            st_valid <= '0;
            st_writ  <= '0;
            st_dirty <= '0;
        end else if (upd_en) begin
            st_valid[set_i][upd_way] <= upd_st.valid;
            st_writ[set_i][upd_way]  <= upd_st.writable;
            st_dirty[set_i][upd_way] <= upd_st.dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (upd_en && upd_tag_en)  tag_q[set_i][upd_way]  <= tag_i;
        if (upd_en && upd_data_en) data_q[set_i][upd_way] <= upd_data;
    end

    // registered outcome, response and push
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_code   <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            wb_push    <= 1'b0;
            wb_addr    <= '0;
            wb_data    <= '0;
            wb_time    <= '0;
        end else begin
            out_valid  <= out_en;
            out_code   <= out_en ? code : 2'd0;
            resp_valid <= rsp_en;
            resp_data  <= rsp_dat;
            wb_push    <= push_en;
            if (push_en) begin
                wb_addr <= {vic_tag, set_i};
                wb_data <= data_q[set_i][vic_way];
                wb_time <= now_cycle + TIME_W'(HIT_LAT);
            end
        end
    end

    cc_sat_counters #(.NCMD(4), .CNT_W(CNT_W), .CMD_W(2)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .bump_hit  (cnt_hit),
        .bump_miss (cnt_miss),
        .cmd       (req_cmd),
        .hit_vec   (hit_count),
        .miss_vec  (miss_count)
    );
endmodule

// File: rtl/cache_ctl_chk.sv
module cache_ctl_chk #(
    parameter int BLK_W = 64,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_cmd,
    input logic             fill_valid,
    input logic             out_valid,
    input logic [1:0]       out_code,
    input logic             resp_valid,
    input logic [BLK_W-1:0] resp_data,
    input logic             wb_push,
    input logic [4*CNT_W-1:0] hit_count,
    input logic [4*CNT_W-1:0] miss_count
);
    assert_outcome_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> out_valid);

    assert_grant_holds_req_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fill_valid) |=> !out_valid);

    assert_scfail_shape_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_code == 2'd2) |->
            ($past(req_cmd) == 2'd2 && resp_valid && resp_data == '0));

    assert_wb_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_cmd == 2'd3) |=> !resp_valid);

    assert_push_source_R8: assert property (@(posedge clk) disable iff (rst)
        wb_push |-> $past(fill_valid || (req_valid && req_ready && req_cmd == 2'd3)));

    assert_counters_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind cache_ctl cache_ctl_chk #(.BLK_W(BLK_BYTES*8), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_cache_ctl.sv
module sim_cache_ctl;
    localparam int BA_W  = 13;
    localparam int CNT_W = 4;

    logic clk = 0, rst = 1;
    logic req_valid = 0, pin_valid = 0, fill_valid = 0, fill_excl = 0;
    logic [1:0] req_cmd = 0;
    logic [BA_W-1:0] req_addr = 0, pin_addr = 0, fill_addr = 0;
    logic [7:0] req_size = 8;
    logic [63:0] req_data = 0, fill_data = 0;
    logic [31:0] now_cycle = 0;
    logic req_ready, out_valid, resp_valid, wb_push;
    logic [1:0] out_code;
    logic [63:0] resp_data, wb_data;
    logic [BA_W-1:0] wb_addr;
    logic [31:0] wb_time;
    logic [4*CNT_W-1:0] hit_count, miss_count;

    int n_run = 0, n_fail = 0;
    int exp_hit [4];
    int exp_miss[4];

    always #2 clk = ~clk;

    cache_ctl #(.CNT_W(CNT_W)) u0 (.*);

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // one request; exp_code 0 hit, 1 forward, 2 sc fail
    task automatic req(input logic [1:0] c, input logic [BA_W-1:0] a, input logic [7:0] sz,
                       input logic [63:0] d, input int exp_code, input string rq);
        @(negedge clk);
        req_valid = 1; req_cmd = c; req_addr = a; req_size = sz; req_data = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk({rq, " out_valid"}, 64'(out_valid), 1);
        chk({rq, " out_code"}, 64'(out_code), 64'(exp_code));
        if (exp_code == 0) begin if (exp_hit[c] < 15) exp_hit[c]++; end
        else begin if (exp_miss[c] < 15) exp_miss[c]++; end
    endtask

    task automatic grant(input logic [BA_W-1:0] a, input logic ex, input logic [63:0] d);
        @(negedge clk);
        fill_valid = 1; fill_addr = a; fill_excl = ex; fill_data = d;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic check_counts(input string tag);
        for (int k = 0; k < 4; k++) begin
            chk({tag, " R11 hit field"},  64'(hit_count[k*CNT_W +: CNT_W]),  64'(exp_hit[k]));
            chk({tag, " R11 miss field"}, 64'(miss_count[k*CNT_W +: CNT_W]), 64'(exp_miss[k]));
        end
    endtask

    localparam logic [BA_W-1:0] A = 4, B = 8, C = 12, D = 5, E = 6, F = 23;

    task automatic t_reset;
        chk("R1 reset out_valid", 64'(out_valid), 0);
        chk("R1 reset resp_valid", 64'(resp_valid), 0);
        chk("R1 reset wb_push", 64'(wb_push), 0);
        chk("R1 reset ready", 64'(req_ready), 1);
        check_counts("R1 reset");
    endtask

    task automatic t_empty_misses;
        req(0, A, 8, 0, 1, "R1 read miss");
        chk("R1 read miss no resp", 64'(resp_valid), 0);
        req(2, A, 8, 64'h55, 2, "R4 sc complete miss");
        chk("R4 sc resp_valid", 64'(resp_valid), 1);
        chk("R4 sc result", resp_data, 0);
    endtask

    task automatic t_wb_absorb;
        req(3, A, 8, 64'hA1A1, 0, "R6 wb alloc");
        chk("R9 wb no resp", 64'(resp_valid), 0);
        chk("R8 clean victim no push", 64'(wb_push), 0);
        req(0, A, 8, 0, 0, "R6 read after alloc");
        chk("R2 read data", resp_data, 64'hA1A1);
        req(1, A, 8, 64'h77, 1, "R3 write read-only");
        chk("R3 write no resp", 64'(resp_valid), 0);
        req(2, A, 8, 64'h77, 1, "R3 sc read-only not fail");
        chk("R3 sc no resp", 64'(resp_valid), 0);
        req(3, A, 8, 64'hA2A2, 0, "R5 wb on read-only hit");
        chk("R9 wb hit no resp", 64'(resp_valid), 0);
        req(0, A, 8, 0, 0, "R5 read back");
        chk("R5 new data", resp_data, 64'hA2A2);
        req(1, A, 8, 64'h99, 1, "R5 still read-only");
        check_counts("R5/R6");
    endtask

    task automatic t_size;
        req(3, F, 4, 64'hBAD, 1, "R10 wrong size wb");
        req(0, F, 8, 0, 1, "R10 nothing allocated");
    endtask

    task automatic t_grant_excl;
        grant(D, 1, 64'hD0D0);
        req(0, D, 8, 0, 0, "R12 read granted");
        chk("R12 grant data", resp_data, 64'hD0D0);
        req(1, D, 8, 64'hD1, 0, "R2 write writable");
        chk("R2 write resp", 64'(resp_valid), 1);
        chk("R2 write resp data", resp_data, 0);
        req(2, D, 8, 64'hD2, 0, "R2 sc writable");
        chk("R2 sc success", resp_data, 1);
        req(0, D, 8, 0, 0, "R2 read after sc");
        chk("R2 sc data", resp_data, 64'hD2);
    endtask

    task automatic t_pin_and_evict;
        req(3, B, 8, 64'hB0B0, 0, "R6 wb second way");
        pin_valid = 1; pin_addr = A;
        req(3, C, 8, 64'hC0C0, 1, "R7 pinned victim");
        chk("R7 no push", 64'(wb_push), 0);
        req(0, C, 8, 0, 1, "R7 not installed");
        req(0, A, 8, 0, 0, "R7 victim kept");
        chk("R7 victim data", resp_data, 64'hA2A2);
        pin_valid = 0;
        now_cycle = 1000;
        req(3, C, 8, 64'hC1C1, 0, "R8 evict dirty");
        chk("R8 push", 64'(wb_push), 1);
        chk("R8 push addr", 64'(wb_addr), 64'(A));
        chk("R8 push data", wb_data, 64'hA2A2);
        chk("R8 push time", 64'(wb_time), 1003);
        req(0, A, 8, 0, 1, "R6 victim gone");
        check_counts("R7/R8");
    endtask

    task automatic t_collision;
        @(negedge clk);
        fill_valid = 1; fill_addr = E; fill_excl = 1; fill_data = 64'hE0;
        req_valid = 1; req_cmd = 0; req_addr = B; req_size = 8;
        #1;
        chk("R1 ready low under grant", 64'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 held request no outcome", 64'(out_valid), 0);
        fill_valid = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk("R1 held request done", 64'(out_valid), 1);
        chk("R1 held request code", 64'(out_code), 0);
        chk("R2 held request data", resp_data, 64'hB0B0);
        if (exp_hit[0] < 15) exp_hit[0]++;
        req(1, E, 8, 64'hE1, 0, "R12 granted during collision");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 20; i++) req(0, F, 8, 0, 1, "R11 saturate loop");
        chk("R11 read miss saturated", 64'(miss_count[0 +: CNT_W]), 15);
        check_counts("R11 final");
    endtask

    logic done = 0;
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin exp_hit[k] = 0; exp_miss[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_empty_misses();
        t_wb_absorb();
        t_size();
        t_grant_excl();
        t_pin_and_evict();
        t_collision();
        t_saturate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule